// File: doc/BRIEF.md
# Multiplexed-Bus Address Decoder

This block sits beside an 8051-style controller whose lower address byte and data share one set of pins. While the address strobe is high the block lets the lower byte through, and it keeps that byte after the strobe falls. The block puts the low byte together with the separate upper byte and one external select bit. That select bit acts as a twentieth address line. From this effective address the block drives active-low selects for four 8 KB program-memory blocks, a 2 KB data RAM, a 2 KB I/O register window and three off-board address ranges.

Program-memory selects respond only to the program-store strobe. The RAM, the I/O window and the off-board selects respond only to the data read or write strobes. For this reason program space and data space can use the same addresses. The RAM and the I/O window cover the same 16-bit range, and the external select bit alone decides between them. A spare output gives a fixed three-input combinational function of three logic inputs.

Top module: `mux_bus_decoder`

## Requirements
- R1: `addr_lo_o` equals `ad_i` while `ale_i` is high. After `ale_i` falls it holds the last value seen with `ale_i` high, whatever `ad_i` does afterwards.
- R2: An active-high `rst` clears the held low byte to 0x00. While `ale_i` is low during or after reset, `addr_lo_o` reads 0x00.
- R3: With `psen_n_i` low, `ext_sel_i` low and `addr_hi_i[7]` (A15) low, exactly `prog_sel_n_o[k]` is 0, where k = `addr_hi_i[6:5]` (A14:A13). Otherwise all four are 1.
- R4: With `psen_n_i` high, all program selects are 1, whatever the state of `rd_n_i`.
- R5: `ram_sel_n_o` is 0 when `rd_n_i` or `wr_n_i` is low, `ext_sel_i` is 0, and `addr_hi_i[7:3]` (A15..A11) is all zero.
- R6: `iowin_sel_n_o` is 0 under the same strobe and address condition as R5, but with `ext_sel_i` = 1. It is never 0 while `ext_sel_i` is 0.
- R7: During a data strobe, `offb_sel_n_o[0]` is 0 for 0xD000–0xDFFF, `offb_sel_n_o[1]` is 0 for 0xC000–0xC7FF and `offb_sel_n_o[2]` is 0 for 0xC800–0xCFFF. `ext_sel_i` has no effect on these selects.
- R8: `func_o` is the function of A=`logic_in_i[2]`, B=`logic_in_i[1]`, C=`logic_in_i[0]` that gives 0,1,1,0,1,1,0,1 for ABC = 000 through 111.
- R9: No two program selects are low together. No two of the data-strobe selects (RAM, I/O window, off-board) are low together, for any address and any value of `ext_sel_i`.
- R10: With `rd_n_i` and `wr_n_i` both high, the RAM, I/O-window and off-board selects are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the low address byte |
| rst | input | 1 | Asynchronous reset, active high |
| ad_i | input | 8 | Multiplexed low address / data lines |
| addr_hi_i | input | 8 | Upper address byte A15..A8 |
| ale_i | input | 1 | Address strobe, active high |
| psen_n_i | input | 1 | Program-store strobe, active low |
| rd_n_i | input | 1 | Data read strobe, active low |
| wr_n_i | input | 1 | Data write strobe, active low |
| ext_sel_i | input | 1 | External select bit, used as A19 |
| logic_in_i | input | 3 | Logic inputs A,B,C at bits 2,1,0 |
| addr_lo_o | output | 8 | Latched low address byte |
| prog_sel_n_o | output | 4 | Program-memory block selects, active low |
| ram_sel_n_o | output | 1 | Data-RAM select, active low |
| iowin_sel_n_o | output | 1 | I/O window select, active low |
| offb_sel_n_o | output | 3 | Off-board range selects, active low |
| func_o | output | 1 | Combinational function output |

## Verification
The only state in the block is the held low byte. If it is wrong, `addr_lo_o` shows the fault in the first cycle after the address strobe falls. It also shows the fault in the first cycle after reset while the strobe is low. The decode paths have no state, so a wrong term shows up on the select outputs in the same cycle as the address that hits it. The bench walks through all 2^17 combinations of upper address, low byte and external select bit. It compares every output against its own model on each clock, which catches such a fault as soon as any address exposes it.

// File: rtl/mux_bus_decoder.sv
`timescale 1ns/1ps
module mux_bus_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] ad_i,
  input  logic [7:0] addr_hi_i,
  input  logic       ale_i,
  input  logic       psen_n_i,
  input  logic       rd_n_i,
  input  logic       wr_n_i,
  input  logic       ext_sel_i,
  input  logic [2:0] logic_in_i,
  output logic [7:0] addr_lo_o,
  output logic [3:0] prog_sel_n_o,
  output logic       ram_sel_n_o,
  output logic       iowin_sel_n_o,
  output logic [2:0] offb_sel_n_o,
  output logic       func_o
);
  localparam logic [7:0] FUNC_TABLE = 8'b1011_0110;

  logic [7:0] lo_q;
  logic       data_stb;
  logic       low_2k;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        lo_q <= 8'h00;
    else if (ale_i) lo_q <= ad_i;
  end

  assign addr_lo_o = ale_i ? ad_i : lo_q;

  assign data_stb = ~rd_n_i | ~wr_n_i;
  assign low_2k   = (addr_hi_i[7:3] == 5'b00000);

  for (genvar k = 0; k < 4; k++) begin : g_prog
    assign prog_sel_n_o[k] = ~(~psen_n_i & ~ext_sel_i & ~addr_hi_i[7] &
                               (addr_hi_i[6:5] == k[1:0]));
  end

  assign ram_sel_n_o     = ~(data_stb & ~ext_sel_i & low_2k);
  assign iowin_sel_n_o   = ~(data_stb &  ext_sel_i & low_2k);
  assign offb_sel_n_o[0] = ~(data_stb & (addr_hi_i[7:4] == 4'b1101));
  assign offb_sel_n_o[1] = ~(data_stb & (addr_hi_i[7:3] == 5'b11000));
  assign offb_sel_n_o[2] = ~(data_stb & (addr_hi_i[7:3] == 5'b11001));

  assign func_o = FUNC_TABLE[logic_in_i];

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!ale_i && !$past(ale_i)) |-> (addr_lo_o == $past(addr_lo_o)));

  assert_prog_psen_R4: assert property (@(posedge clk) disable iff (rst)
    psen_n_i |-> (prog_sel_n_o == 4'hF));

  assert_io_ext_R6: assert property (@(posedge clk) disable iff (rst)
    !iowin_sel_n_o |-> ext_sel_i);

  assert_prog_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~prog_sel_n_o));

  assert_data_excl_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~{ram_sel_n_o, iowin_sel_n_o, offb_sel_n_o}));

  assert_data_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_n_i && wr_n_i) |-> ({ram_sel_n_o, iowin_sel_n_o, offb_sel_n_o} == 5'h1F));
endmodule

// File: tb/mux_bus_decoder_bench.sv
`timescale 1ns/1ps
module mux_bus_decoder_bench;
  logic clk = 0, rst = 1;
  logic [7:0] ad = 0, hi = 0;
  logic ale = 0, psen_n = 1, rd_n = 1, wr_n = 1, ext = 0;
  logic [2:0] lin = 0;
  logic [7:0] addr_lo;
  logic [3:0] prog_n;
  logic ram_n, io_n, func;
  logic [2:0] offb_n;
  int errors = 0, checks = 0;
  bit done = 0;
  bit cmp_on = 0;
  logic [7:0] m_lo;

  always #4 clk = ~clk;

  mux_bus_decoder u_mux_bus_decoder (
    .clk(clk), .rst(rst), .ad_i(ad), .addr_hi_i(hi), .ale_i(ale),
    .psen_n_i(psen_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .ext_sel_i(ext),
    .logic_in_i(lin), .addr_lo_o(addr_lo), .prog_sel_n_o(prog_n),
    .ram_sel_n_o(ram_n), .iowin_sel_n_o(io_n), .offb_sel_n_o(offb_n),
    .func_o(func));

  always @(posedge clk or posedge rst)
    if (rst) m_lo <= 8'h00; else if (ale) m_lo <= ad;

  function automatic logic fn_ref(input logic [2:0] v);
    case (v)
      3'd0, 3'd3, 3'd6: return 1'b0;
      default:          return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on && !rst && !done) begin
    int lo, eff, a16;
    bit dstb, pstb;
    logic [3:0] e_prog;
    logic [2:0] e_off;
    lo   = ale ? ad : m_lo;
    eff  = (ext ? 32'h80000 : 0) + hi * 256 + lo;
    a16  = eff % 65536;
    dstb = !rd_n || !wr_n;
    pstb = !psen_n;
    e_prog = 4'hF;
    if (pstb && eff < 32'h8000) e_prog[eff / 8192] = 1'b0;
    e_off[0] = !(dstb && a16 >= 'hD000 && a16 <= 'hDFFF);
    e_off[1] = !(dstb && a16 >= 'hC000 && a16 <= 'hC7FF);
    e_off[2] = !(dstb && a16 >= 'hC800 && a16 <= 'hCFFF);
    chk("R1", "addr_lo", addr_lo, lo);
    chk("R3", "prog_sel_n", prog_n, e_prog);
    chk("R5", "ram_sel_n", ram_n, !(dstb && eff < 'h800));
    chk("R6", "iowin_sel_n", io_n, !(dstb && eff >= 'h80000 && eff < 'h80800));
    chk("R7", "offb_sel_n", offb_n, e_off);
    chk("R8", "func", func, fn_ref(lin));
    chk("R9", "prog exclusive", $countones(~prog_n) <= 1, 1);
    chk("R9", "data exclusive", $countones(~{ram_n, io_n, offb_n}) <= 1, 1);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic at_neg(); @(negedge clk); #1; endtask

  initial begin
    #(180000 * 8);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    ad = 8'h5A;
    repeat (3) step();
    at_neg(); chk("R2", "addr_lo in reset", addr_lo, 8'h00);
    step(); rst = 0; cmp_on = 1;
    at_neg(); chk("R2", "addr_lo after reset", addr_lo, 8'h00);
    step(); ale = 1; ad = 8'h3C;
    at_neg(); chk("R1", "transparent", addr_lo, 8'h3C);
    step(); ale = 0; ad = 8'hFF;
    step();
    at_neg(); chk("R1", "held", addr_lo, 8'h3C);
    step(); rst = 1; step(); rst = 0;
    at_neg(); chk("R2", "mid-run reset", addr_lo, 8'h00);
    for (int b = 0; b < 4; b++) begin
      step(); psen_n = 0; hi = 8'(b * 32 + 3);
      at_neg(); chk("R3", "prog block", prog_n, 4'hF & ~(4'b1 << b));
    end
    step(); psen_n = 1; rd_n = 0; hi = 8'h00;
    at_neg(); chk("R4", "prog idle on rd", prog_n, 4'hF);
    chk("R5", "ram on rd", ram_n, 0);
    step(); rd_n = 1;
    at_neg(); chk("R10", "ram idle", ram_n, 1);
    step(); wr_n = 0; ext = 1;
    at_neg(); chk("R6", "io on wr", io_n, 0); chk("R5", "ram off ext", ram_n, 1);
    step(); hi = 8'hD4;
    at_neg(); chk("R7", "offb D000", offb_n, 3'b110);
    step(); hi = 8'hC7; ext = 0;
    at_neg(); chk("R7", "offb C000", offb_n, 3'b101);
    step(); hi = 8'hCF;
    at_neg(); chk("R7", "offb C800", offb_n, 3'b011);
    step(); wr_n = 1;
    at_neg(); chk("R10", "offb idle", offb_n, 3'b111);
    for (int v = 0; v < 8; v++) begin
      step(); lin = 3'(v);
      at_neg(); chk("R8", "func", func, (8'b1011_0110 >> v) & 1);
    end
    for (int k = 0; k < (1 << 17); k++) begin
      step();
      ext = k[16]; hi = k[15:8]; ad = k[7:0]; ale = 1;
      psen_n = 0; rd_n = 0; wr_n = 1; lin = k[2:0];
    end
    step(); step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule